// File: doc/BRIEF.md
# Set-Associative Tag Directory with Not-Recently-Used Replacement

This block keeps the tag and valid state of a 32 KB cache whose lines are 32 bytes long. The lines are arranged as 128 sets of 8 ways. A client strobes a lookup with a 32-bit byte address. One clock later the block returns three results: whether the line is resident, which way holds it, and which way would be replaced if the line had to be brought in. The data array, the memory side and any write-back logic sit outside the block. They use the way numbers it reports.

A separate allocate command installs a line. If the set still has an empty way, the lowest-numbered empty way receives the line. Otherwise the block picks the lowest-numbered way whose reference bit is clear. Every hit and every fill marks the way's reference bit. When a mark would leave all eight marks of a set at 1, the other seven are cleared. A flush input clears every valid bit and every reference mark in one cycle, and so does the synchronous reset.

Top module: `tagdir_top`

## Requirements
- R1: The byte address splits into a line offset (bits 4:0), a set index (bits 11:5) and a tag (bits 31:12). Addresses that differ only in the offset refer to the same line.
- R2: `rsp_valid_o` is 1 in exactly the cycle after a cycle with `lkp_req_i` high, and 0 otherwise. The other outputs change only at such responses.
- R3: A response reports `hit_o`=1 when some valid way of the indexed set holds the address tag, with `hit_way_o` giving that way. Otherwise it reports `hit_o`=0 with `hit_way_o`=0.
- R4: An allocate of an address that is not resident writes its tag into a way and marks that way valid on the next clock edge. The way chosen is the lowest-numbered invalid way of the set, if any exists.
- R5: When all 8 ways of the set are valid, the victim is the lowest-numbered way whose reference mark is 0. `victim_way_o` reports the victim the set would give at the time of the request.
- R6: A hit or fill sets the way's reference mark. If that would leave all 8 marks of the set at 1, only that way's mark stays set.
- R7: A lookup hit marks the hit way, provided `alloc_i` is low in the same cycle.
- R8: An allocate of an address already resident writes no tag. It only marks the way that holds it, so no second copy appears.
- R9: After reset, every way is invalid, every mark is clear, and all outputs are 0.
- R10: `flush_i` clears all valid bits and marks on the next edge. A lookup in a flush cycle responds with `hit_o`=0, `hit_way_o`=0 and `victim_way_o`=0. An allocate in a flush cycle is ignored.
- R11: A lookup in the same cycle as an allocate is answered against the state before the allocate. Its own reference update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Invalidate every line and clear all marks |
| lkp_req_i | input | 1 | Lookup strobe |
| lkp_addr_i | input | 32 | Lookup byte address |
| alloc_i | input | 1 | Allocate strobe |
| alloc_addr_i | input | 32 | Byte address of the line to install |
| rsp_valid_o | output | 1 | Lookup response present |
| hit_o | output | 1 | Lookup hit |
| hit_way_o | output | 3 | Way that hit |
| victim_way_o | output | 3 | Way that would be replaced |

## Verification
The bench fills one set way by way. It then walks the reference marks through the point where the eighth mark would set. A design that does not clear the other marks there would stick its victim at way 0 or fall back to a fixed way, and the bench would see the wrong victim. It allocates an address that is already resident. A design that duplicates the line would overwrite the current victim, which later lookups expose as a miss. It also overlaps a lookup hit with an allocate to another set, and issues lookups and allocates during a flush. A design that kept the dropped reference update would shift the next victim by one way. A design that leaked state through the flush would report a stale hit. A random phase over two contended sets is compared against a behavioural model on every clock.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_LINE_BYTES = 32;
  localparam int unsigned DEF_SETS       = 128;
  localparam int unsigned DEF_WAYS       = 8;
endpackage

// File: rtl/tagdir_store.sv
module tagdir_store #(
  parameter int unsigned SETS  = tagdir_pkg::DEF_SETS,
  parameter int unsigned WAYS  = tagdir_pkg::DEF_WAYS,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic [IDX_W-1:0]           a_idx,
  output logic [WAYS-1:0][TAG_W-1:0] a_tags,
  output logic [WAYS-1:0]            a_valid,
  output logic [WAYS-1:0]            a_ref,
  input  logic [IDX_W-1:0]           b_idx,
  output logic [WAYS-1:0][TAG_W-1:0] b_tags,
  output logic [WAYS-1:0]            b_valid,
  output logic [WAYS-1:0]            b_ref,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       ref_en,
  input  logic [IDX_W-1:0]           ref_idx,
  input  logic [WAYS-1:0]            ref_val
);
  logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
  logic [WAYS-1:0]            vld_mem [SETS];
  logic [WAYS-1:0]            ref_mem [SETS];

  // tag storage carries no reset so it can map onto plain RAM-style flops
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx][wr_way] <= wr_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SETS; s++) begin
        vld_mem[s] <= '0;
        ref_mem[s] <= '0;
      end
    end else begin
      if (wr_en)  vld_mem[wr_idx][wr_way] <= 1'b1;
      if (ref_en) ref_mem[ref_idx] <= ref_val;
    end
  end

  assign a_tags  = tag_mem[a_idx];
  assign a_valid = vld_mem[a_idx];
  assign a_ref   = ref_mem[a_idx];
  assign b_tags  = tag_mem[b_idx];
  assign b_valid = vld_mem[b_idx];
  assign b_ref   = ref_mem[b_idx];

  // R6: a set never holds all of its marks at once
  p_marks_never_full_r6: assert property (@(posedge clk) disable iff (rst)
    !(&a_ref));

  // R4: a tag write leaves its way valid in the next cycle
  p_write_sets_valid_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !flush) |=> vld_mem[$past(wr_idx)][$past(wr_way)]);
endmodule

// File: rtl/tagdir_match.sv
module tagdir_match #(
  parameter int unsigned WAYS  = tagdir_pkg::DEF_WAYS,
  parameter int unsigned TAG_W = 20,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [WAYS-1:0]            valid,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid[w] && (tags[w] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/tagdir_victim.sv
module tagdir_victim #(
  parameter int unsigned WAYS = tagdir_pkg::DEF_WAYS,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  marks,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] free_way, cold_way;
  logic             any_free;

  always_comb begin
    free_way = '0;
    cold_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) free_way = WAY_W'(w);
      if (!marks[w]) cold_way = WAY_W'(w);
    end
  end

  assign any_free = !(&valid);
  assign victim   = any_free ? free_way : cold_way;
endmodule

// File: rtl/tagdir_top.sv
module tagdir_top #(
  parameter int unsigned ADDR_W     = tagdir_pkg::DEF_ADDR_W,
  parameter int unsigned LINE_BYTES = tagdir_pkg::DEF_LINE_BYTES,
  parameter int unsigned SETS       = tagdir_pkg::DEF_SETS,
  parameter int unsigned WAYS       = tagdir_pkg::DEF_WAYS,
  localparam int unsigned OFF_W = $clog2(LINE_BYTES),
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              lkp_req_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  output logic              rsp_valid_o,
  output logic              hit_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [WAY_W-1:0]  victim_way_o
);
  logic [IDX_W-1:0] a_idx, b_idx;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [WAYS-1:0][TAG_W-1:0] a_tags, b_tags;
  logic [WAYS-1:0]  a_valid, b_valid, a_ref, b_ref;
  logic [WAYS-1:0]  a_hit_vec, b_vec_unused;
  logic             a_hit, b_hit;
  logic [WAY_W-1:0] a_hit_way, b_hit_way, a_victim, b_victim;
  logic             wr_en, ref_en;
  logic [WAY_W-1:0] fill_way;
  logic [IDX_W-1:0] ref_idx;
  logic [WAYS-1:0]  ref_val;
  logic             offs_unused;

  assign a_idx = lkp_addr_i[OFF_W +: IDX_W];
  assign a_tag = lkp_addr_i[ADDR_W-1 -: TAG_W];
  assign b_idx = alloc_addr_i[OFF_W +: IDX_W];
  assign b_tag = alloc_addr_i[ADDR_W-1 -: TAG_W];
  assign offs_unused = ^{lkp_addr_i[OFF_W-1:0], alloc_addr_i[OFF_W-1:0]};

  function automatic logic [WAYS-1:0] mark_way(input logic [WAYS-1:0] cur,
                                               input logic [WAY_W-1:0] w);
    logic [WAYS-1:0] bit_w, nxt;
    bit_w = {{(WAYS-1){1'b0}}, 1'b1} << w;
    nxt   = cur | bit_w;
    if (&nxt) nxt = bit_w;
    return nxt;
  endfunction

  tagdir_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) store_i (
    .clk(clk), .rst(rst), .flush(flush_i),
    .a_idx(a_idx), .a_tags(a_tags), .a_valid(a_valid), .a_ref(a_ref),
    .b_idx(b_idx), .b_tags(b_tags), .b_valid(b_valid), .b_ref(b_ref),
    .wr_en(wr_en), .wr_idx(b_idx), .wr_way(b_victim), .wr_tag(b_tag),
    .ref_en(ref_en), .ref_idx(ref_idx), .ref_val(ref_val)
  );

  tagdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_lkp_i (
    .tags(a_tags), .valid(a_valid), .tag(a_tag),
    .hit_vec(a_hit_vec), .hit(a_hit), .hit_way(a_hit_way)
  );

  tagdir_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_alc_i (
    .tags(b_tags), .valid(b_valid), .tag(b_tag),
    .hit_vec(b_vec_unused), .hit(b_hit), .hit_way(b_hit_way)
  );

  tagdir_victim #(.WAYS(WAYS)) victim_lkp_i (
    .valid(a_valid), .marks(a_ref), .victim(a_victim)
  );

  tagdir_victim #(.WAYS(WAYS)) victim_alc_i (
    .valid(b_valid), .marks(b_ref), .victim(b_victim)
  );

  // allocate owns the mark update; a lookup hit marks only when no allocate
  assign fill_way = b_hit ? b_hit_way : b_victim;
  assign wr_en    = alloc_i && !flush_i && !b_hit;

  always_comb begin
    ref_en  = 1'b0;
    ref_idx = a_idx;
    ref_val = a_ref;
    if (!flush_i) begin
      if (alloc_i) begin
        ref_en  = 1'b1;
        ref_idx = b_idx;
        ref_val = mark_way(b_ref, fill_way);
      end else if (lkp_req_i && a_hit) begin
        ref_en  = 1'b1;
        ref_val = mark_way(a_ref, a_hit_way);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      hit_way_o    <= '0;
      victim_way_o <= '0;
    end else begin
      rsp_valid_o <= lkp_req_i;
      if (lkp_req_i) begin
        if (flush_i) begin
          hit_o        <= 1'b0;
          hit_way_o    <= '0;
          victim_way_o <= '0;
        end else begin
          hit_o        <= a_hit;
          hit_way_o    <= a_hit_way;
          victim_way_o <= a_victim;
        end
      end
    end
  end

  // R2: one response per strobe, one cycle later
  p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (rst)
    lkp_req_i |=> rsp_valid_o);
  p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (rst)
    !lkp_req_i |=> !rsp_valid_o);

  // R3: a tag is resident in at most one way of its set
  p_single_match_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(a_hit_vec));

  // R4: while the set has a free way the victim is a free way
  p_free_way_first_r4: assert property (@(posedge clk) disable iff (rst)
    !(&a_valid) |-> !a_valid[a_victim]);

  // R10: a lookup coinciding with a flush reports a miss
  p_flush_miss_r10: assert property (@(posedge clk) disable iff (rst)
    (flush_i && lkp_req_i) |=> !hit_o);
endmodule

// File: tb/tagdir_top_tb_top.sv
`timescale 1ns/1ps
module tagdir_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush_i = 1'b0;
  logic        lkp_req_i = 1'b0;
  logic [31:0] lkp_addr_i = '0;
  logic        alloc_i = 1'b0;
  logic [31:0] alloc_addr_i = '0;
  logic        rsp_valid_o, hit_o;
  logic [2:0]  hit_way_o, victim_way_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tagdir_top dut_i (
    .clk(clk), .rst(rst), .flush_i(flush_i),
    .lkp_req_i(lkp_req_i), .lkp_addr_i(lkp_addr_i),
    .alloc_i(alloc_i), .alloc_addr_i(alloc_addr_i),
    .rsp_valid_o(rsp_valid_o), .hit_o(hit_o),
    .hit_way_o(hit_way_o), .victim_way_o(victim_way_o)
  );

  // behavioural reference
  bit [19:0] m_tag [128][8];
  bit        m_vld [128][8];
  bit        m_ref [128][8];
  bit        e_rsp;
  bit        e_hit;
  int        e_way, e_vic;

  function automatic int find(int s, bit [19:0] t);
    for (int w = 0; w < 8; w++) if (m_vld[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int pick(int s);
    for (int w = 0; w < 8; w++) if (!m_vld[s][w]) return w;
    for (int w = 0; w < 8; w++) if (!m_ref[s][w]) return w;
    return 0;
  endfunction

  task automatic touch(int s, int w);
    int n = 0;
    m_ref[s][w] = 1'b1;
    for (int k = 0; k < 8; k++) n += m_ref[s][k];
    if (n == 8) for (int k = 0; k < 8; k++) m_ref[s][k] = (k == w);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 128; s++)
        for (int w = 0; w < 8; w++) begin m_vld[s][w] = 0; m_ref[s][w] = 0; end
      e_rsp = 0; e_hit = 0; e_way = 0; e_vic = 0;
    end else begin
      int ls, lw, as_, aw;
      ls = int'(lkp_addr_i[11:5]);
      lw = -1;
      e_rsp = lkp_req_i;
      if (lkp_req_i) begin
        if (flush_i) begin
          e_hit = 0; e_way = 0; e_vic = 0;
        end else begin
          lw = find(ls, lkp_addr_i[31:12]);
          e_hit = (lw >= 0);
          e_way = (lw >= 0) ? lw : 0;
          e_vic = pick(ls);
        end
      end
      if (flush_i) begin
        for (int s = 0; s < 128; s++)
          for (int w = 0; w < 8; w++) begin m_vld[s][w] = 0; m_ref[s][w] = 0; end
      end else if (alloc_i) begin
        as_ = int'(alloc_addr_i[11:5]);
        aw = find(as_, alloc_addr_i[31:12]);
        if (aw < 0) begin
          aw = pick(as_);
          m_tag[as_][aw] = alloc_addr_i[31:12];
          m_vld[as_][aw] = 1'b1;
        end
        touch(as_, aw);
      end else if (lkp_req_i && lw >= 0) begin
        touch(ls, lw);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 rsp_valid", int'(rsp_valid_o), int'(e_rsp));
      if (e_rsp) begin
        chk("R3 hit", int'(hit_o), int'(e_hit));
        chk("R3 hit_way", int'(hit_way_o), e_way);
        chk("R5 victim", int'(victim_way_o), e_vic);
      end
    end
  end

  function automatic logic [31:0] mk(int t, int s, int off);
    return {20'(t), 7'(s), 5'(off)};
  endfunction

  task automatic lookup(logic [31:0] a);
    lkp_req_i = 1; lkp_addr_i = a;
    @(negedge clk);
    lkp_req_i = 0;
    @(negedge clk);
  endtask

  task automatic alloc(logic [31:0] a);
    alloc_i = 1; alloc_addr_i = a;
    @(negedge clk);
    alloc_i = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9: cleared outputs and empty directory
    chk("R9 rsp_valid", int'(rsp_valid_o), 0);
    chk("R9 hit", int'(hit_o), 0);
    lkp_req_i = 1; lkp_addr_i = mk('h55, 5, 0);
    @(negedge clk); lkp_req_i = 0;
    chk("R2 response cycle", int'(rsp_valid_o), 1);
    chk("R9 miss after reset", int'(hit_o), 0);
    chk("R9 victim after reset", int'(victim_way_o), 0);
    @(negedge clk);
    chk("R2 single response", int'(rsp_valid_o), 0);

    // R4 fill order and R1 offset independence
    for (int k = 0; k < 8; k++) begin
      alloc(mk('h100 + k, 5, 0));
      lookup(mk('h100 + k, 5, 3 * k + 1));
      chk("R4 fill hit", int'(hit_o), 1);
      chk("R1 R4 fill way", int'(hit_way_o), k);
    end
    // marks now {7}: victim is way 0
    lookup(mk('h200, 5, 0));
    chk("R6 victim after wrap", int'(victim_way_o), 0);
    // R7: hits on 3 and 0 move the victim to way 1
    lookup(mk('h103, 5, 31));
    chk("R7 hit way3", int'(hit_way_o), 3);
    lookup(mk('h100, 5, 0));
    lookup(mk('h200, 5, 0));
    chk("R7 victim after hits", int'(victim_way_o), 1);
    // R5: replacement lands on way 1
    alloc(mk('h201, 5, 0));
    lookup(mk('h201, 5, 8));
    chk("R5 replaced way", int'(hit_way_o), 1);
    lookup(mk('h101, 5, 0));
    chk("R5 evicted miss", int'(hit_o), 0);
    // R6: marks {0,1,3,7}; hits on 2,4,5 then 6 wrap to {6}
    lookup(mk('h102, 5, 0));
    lookup(mk('h104, 5, 0));
    lookup(mk('h105, 5, 0));
    lookup(mk('h106, 5, 0));
    lookup(mk('h300, 5, 0));
    chk("R6 victim after clear", int'(victim_way_o), 0);
    lookup(mk('h100, 5, 0));
    lookup(mk('h300, 5, 0));
    chk("R6 victim next", int'(victim_way_o), 1);
    // R8: re-allocating a resident tag writes nothing
    alloc(mk('h102, 5, 0));
    lookup(mk('h300, 5, 0));
    chk("R8 victim unchanged", int'(victim_way_o), 1);
    lookup(mk('h201, 5, 0));
    chk("R8 neighbour kept", int'(hit_o), 1);
    chk("R8 neighbour way", int'(hit_way_o), 1);
    // marks {0,1,2,6}. R11: lookup and allocate of same new tag together
    lkp_req_i = 1; lkp_addr_i = mk('h400, 5, 0);
    alloc_i = 1; alloc_addr_i = mk('h400, 5, 0);
    @(negedge clk); lkp_req_i = 0; alloc_i = 0;
    chk("R11 pre-write miss", int'(hit_o), 0);
    chk("R11 pre-write victim", int'(victim_way_o), 3);
    lookup(mk('h400, 5, 0));
    chk("R11 installed way", int'(hit_way_o), 3);
    // R11: hit on way4 alongside an allocate elsewhere leaves way4 unmarked
    lkp_req_i = 1; lkp_addr_i = mk('h104, 5, 0);
    alloc_i = 1; alloc_addr_i = mk('h500, 9, 0);
    @(negedge clk); lkp_req_i = 0; alloc_i = 0;
    chk("R11 concurrent hit way", int'(hit_way_o), 4);
    @(negedge clk);
    lookup(mk('h600, 5, 0));
    chk("R11 mark dropped", int'(victim_way_o), 4);

    // R10: flush with lookup and allocate
    flush_i = 1; lkp_req_i = 1; lkp_addr_i = mk('h100, 5, 0);
    @(negedge clk); flush_i = 0; lkp_req_i = 0;
    chk("R10 flush lookup hit", int'(hit_o), 0);
    chk("R10 flush lookup victim", int'(victim_way_o), 0);
    lookup(mk('h100, 5, 0));
    chk("R10 cleared", int'(hit_o), 0);
    lookup(mk('h500, 9, 0));
    chk("R10 cleared other set", int'(hit_o), 0);
    flush_i = 1; alloc_i = 1; alloc_addr_i = mk('h700, 5, 0);
    @(negedge clk); flush_i = 0; alloc_i = 0;
    lookup(mk('h700, 5, 0));
    chk("R10 alloc ignored", int'(hit_o), 0);
    chk("R10 victim empty", int'(victim_way_o), 0);

    // random contention over two sets, checked by the reference
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      lkp_req_i = (r < 60);
      lkp_addr_i = mk('h800 + $urandom_range(0, 11), 6 + $urandom_range(0, 1),
                      $urandom_range(0, 31));
      alloc_i = ($urandom_range(0, 99) < 35);
      alloc_addr_i = mk('h800 + $urandom_range(0, 11), 6 + $urandom_range(0, 1),
                        $urandom_range(0, 31));
      flush_i = ($urandom_range(0, 999) < 4);
      @(negedge clk);
    end
    lkp_req_i = 0; alloc_i = 0; flush_i = 0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule